// File: doc/BRIEF.md
# MMU access permission checker

This block decides, in a single combinational pass, how much access a memory reference receives once its translation descriptor is known. It picks the 2-bit domain field named by a 4-bit domain number out of a 32-bit domain control word. It then applies two checks in sequence. The first is a per-domain override: the domain can be blocked, checked against the permission code (client), or granted everything (manager). The second is a four-way permission code. For code zero, the result depends on the system-protect and ROM-protect control bits and on whether the reference comes from user mode.

The result is a 2-bit access level. A separate grant output compares that level with the write flag of the current reference. An error output flags the reserved domain value. The block has no clock and no state. A page-table walker or load/store unit drives it, and uses the level and grant in the same cycle.

Top module: `mmu_perm_check`

## Requirements
- R1: The `level` output is encoded as 0 = no access, 1 = read-only, 2 = read/write. The value 3 never appears.
- R2: The domain value used is bits [2*dom_num+1 : 2*dom_num] of `dom_ctrl`.
- R3: A domain value of 0 (blocked) yields level 0 for every permission code, mode and control-bit setting.
- R4: A domain value of 3 (manager) yields level 2 for every permission code, mode and control-bit setting.
- R5: A domain value of 2 is reserved. It raises `rsvd_err` and yields level 0. `rsvd_err` is 0 for every other domain value.
- R6: With domain value 1 (client) and permission code 1, privileged references get level 2 and user references get level 0.
- R7: With domain value 1 and permission code 2, privileged references get level 2 and user references get level 1.
- R8: With domain value 1 and permission code 3, all references get level 2.
- R9: With domain value 1 and permission code 0, the result depends on the two protect bits:
  - both bits clear: level 0;
  - only `sys_prot` set: level 1 for privileged references and 0 for user references;
  - only `rom_prot` set: level 1 for all references;
  - both bits set: level 0.
- R10: `granted` is 1 exactly when `level` is strictly greater than `is_write` (1 for a write, 0 for a read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dom_ctrl | input | 32 | Domain control word, 2 bits per domain |
| dom_num | input | 4 | Domain number of the reference |
| perm_code | input | 2 | Permission code from the descriptor |
| is_user | input | 1 | 1 when the reference is made in user mode |
| sys_prot | input | 1 | System-protect control bit |
| rom_prot | input | 1 | ROM-protect control bit |
| is_write | input | 1 | 1 for a write, 0 for a read |
| level | output | 2 | Access level: 0 none, 1 read-only, 2 read/write |
| granted | output | 1 | Reference is allowed |
| rsvd_err | output | 1 | Reserved domain value seen |

## Verification
All three results are purely combinational, so each one is due in the same cycle as its stimulus, with zero register stages. The bench changes inputs on the falling clock edge and samples one time unit later, well before the next rising edge. Every sample therefore sees the settled response to exactly one input vector. For every domain value, the bench sweeps every combination of permission code, mode, protect bits and write flag. It also walks all sixteen domain numbers over two distinct control words.

// File: rtl/mmu_perm_pkg.sv
package mmu_perm_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_RO   = 2'd1,
        LVL_RW   = 2'd2
    } acc_lvl_e;

    typedef enum logic [1:0] {
        DOM_BLOCKED = 2'd0,
        DOM_CLIENT  = 2'd1,
        DOM_RSVD    = 2'd2,
        DOM_MANAGER = 2'd3
    } dom_mode_e;

    typedef enum logic [1:0] {
        PC_CTRL   = 2'd0,
        PC_PRIV   = 2'd1,
        PC_USR_RO = 2'd2,
        PC_OPEN   = 2'd3
    } perm_code_e;

endpackage

// File: rtl/dom_field_sel.sv
module dom_field_sel #(
    parameter int CTRL_W  = 32,
    parameter int FIELD_W = 2,
    localparam int NFIELD = CTRL_W / FIELD_W,
    localparam int IDX_W  = $clog2(NFIELD)
) (
    input  logic [CTRL_W-1:0]  ctrl_word,
    input  logic [IDX_W-1:0]   field_idx,
    output logic [FIELD_W-1:0] field_val
);

    logic [FIELD_W-1:0] fields [NFIELD];

    for (genvar g = 0; g < NFIELD; g++) begin : g_split
        assign fields[g] = ctrl_word[g*FIELD_W +: FIELD_W];
    end

    assign field_val = fields[field_idx];

endmodule

// File: rtl/perm_code_dec.sv
module perm_code_dec
    import mmu_perm_pkg::*;
(
    input  logic [1:0] code,
    input  logic       user_mode,
    input  logic       sys_bit,
    input  logic       rom_bit,
    output acc_lvl_e   code_lvl
);

    always_comb begin
        unique case (perm_code_e'(code))
            PC_OPEN:   code_lvl = LVL_RW;
            PC_USR_RO: code_lvl = user_mode ? LVL_RO : LVL_RW;
            PC_PRIV:   code_lvl = user_mode ? LVL_NONE : LVL_RW;
            PC_CTRL: begin
                unique case ({rom_bit, sys_bit})
                    2'b01:   code_lvl = user_mode ? LVL_NONE : LVL_RO;
                    2'b10:   code_lvl = LVL_RO;
                    2'b00:   code_lvl = LVL_NONE;
                    default: code_lvl = LVL_NONE;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/dom_override.sv
module dom_override
    import mmu_perm_pkg::*;
(
    input  logic [1:0] dom_val,
    input  acc_lvl_e   code_lvl,
    output acc_lvl_e   final_lvl,
    output logic       bad_dom
);

    always_comb begin
        bad_dom = 1'b0;
        unique case (dom_mode_e'(dom_val))
            DOM_BLOCKED: final_lvl = LVL_NONE;
            DOM_CLIENT:  final_lvl = code_lvl;
            DOM_MANAGER: final_lvl = LVL_RW;
            DOM_RSVD: begin
                final_lvl = LVL_NONE;
                bad_dom   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
    import mmu_perm_pkg::*;
#(
    parameter int CTRL_W  = 32,
    parameter int FIELD_W = 2,
    localparam int IDX_W  = $clog2(CTRL_W / FIELD_W)
) (
    input  logic [CTRL_W-1:0] dom_ctrl,
    input  logic [IDX_W-1:0]  dom_num,
    input  logic [1:0]        perm_code,
    input  logic              is_user,
    input  logic              sys_prot,
    input  logic              rom_prot,
    input  logic              is_write,
    output logic [1:0]        level,
    output logic              granted,
    output logic              rsvd_err
);

    logic [FIELD_W-1:0] dom_val;
    acc_lvl_e           code_lvl;
    acc_lvl_e           final_lvl;

    dom_field_sel #(.CTRL_W(CTRL_W), .FIELD_W(FIELD_W)) u_sel (
        .ctrl_word (dom_ctrl),
        .field_idx (dom_num),
        .field_val (dom_val)
    );

    perm_code_dec u_dec (
        .code      (perm_code),
        .user_mode (is_user),
        .sys_bit   (sys_prot),
        .rom_bit   (rom_prot),
        .code_lvl  (code_lvl)
    );

    dom_override u_ovr (
        .dom_val   (dom_val[1:0]),
        .code_lvl  (code_lvl),
        .final_lvl (final_lvl),
        .bad_dom   (rsvd_err)
    );

    assign level   = final_lvl;
    assign granted = (final_lvl > acc_lvl_e'({1'b0, is_write}));

    always_comb begin
        assert_lvl_legal_R1: assert (level != 2'd3);
        assert_blocked_none_R3: assert (dom_val[1:0] != 2'd0 || level == 2'd0);
        assert_manager_rw_R4: assert (dom_val[1:0] != 2'd3 || level == 2'd2);
        assert_rsvd_none_R5: assert (!rsvd_err || level == 2'd0);
        assert_grant_needs_lvl_R10: assert (!granted || level > {1'b0, is_write});
    end

endmodule

// File: tb/mmu_perm_check_tb_top.sv
module mmu_perm_check_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dom_ctrl = '0;
    logic [3:0]  dom_num = '0;
    logic [1:0]  perm_code = '0;
    logic        is_user = 1'b0;
    logic        sys_prot = 1'b0;
    logic        rom_prot = 1'b0;
    logic        is_write = 1'b0;
    logic [1:0]  level;
    logic        granted;
    logic        rsvd_err;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_perm_check dut_i (
        .dom_ctrl  (dom_ctrl),
        .dom_num   (dom_num),
        .perm_code (perm_code),
        .is_user   (is_user),
        .sys_prot  (sys_prot),
        .rom_prot  (rom_prot),
        .is_write  (is_write),
        .level     (level),
        .granted   (granted),
        .rsvd_err  (rsvd_err)
    );

    // Expected level from the requirement text (R3..R9)
    function automatic logic [1:0] exp_level(input logic [1:0] dv, input logic [1:0] pc,
                                             input logic u, input logic s, input logic r);
        if (dv == 2'd0 || dv == 2'd2) return 2'd0;
        if (dv == 2'd3) return 2'd2;
        if (pc == 2'd3) return 2'd2;
        if (pc == 2'd2) return u ? 2'd1 : 2'd2;
        if (pc == 2'd1) return u ? 2'd0 : 2'd2;
        if (s && !r) return u ? 2'd0 : 2'd1;
        if (r && !s) return 2'd1;
        return 2'd0;
    endfunction

    task automatic check(input string req, input logic [1:0] exp_lvl, input logic exp_err);
        logic exp_gnt;
        exp_gnt = (exp_lvl > {1'b0, is_write});
        vectors++;
        if (level !== exp_lvl || granted !== exp_gnt || rsvd_err !== exp_err) begin
            misses++;
            $display("FAIL %s: dom=%0d pc=%0d u=%0b s=%0b r=%0b w=%0b got lvl=%0d gnt=%0b err=%0b exp lvl=%0d gnt=%0b err=%0b",
                     req, dom_num, perm_code, is_user, sys_prot, rom_prot, is_write,
                     level, granted, rsvd_err, exp_lvl, exp_gnt, exp_err);
        end
    endtask

    task automatic apply(input logic [31:0] c, input logic [3:0] d, input logic [1:0] pc,
                         input logic u, input logic s, input logic r, input logic w);
        @(negedge clk);
        dom_ctrl = c; dom_num = d; perm_code = pc;
        is_user = u; sys_prot = s; rom_prot = r; is_write = w;
        #1;
    endtask

    // Sweep all codes, modes, protect bits and write flags with domain 0 set to dv
    task automatic sweep_domain(input logic [1:0] dv, input string req);
        for (int k = 0; k < 64; k++) begin
            logic [5:0] v;
            v = 6'(k);
            apply({30'h2AAA_AAAA, dv}, 4'd0, v[1:0], v[2], v[3], v[4], v[5]);
            check(req, exp_level(dv, v[1:0], v[2], v[3], v[4]), dv == 2'd2);
        end
    endtask

    task automatic t_idle();
        apply(32'h0, 4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 idle", 2'd0, 1'b0);
    endtask

    task automatic t_select();
        logic [31:0] words [2] = '{32'hE4B1_1B6C, 32'h39C6_D28F};
        for (int w = 0; w < 2; w++) begin
            for (int d = 0; d < 16; d++) begin
                logic [1:0] dv;
                dv = words[w][2*d +: 2];
                apply(words[w], 4'(d), 2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
                check("R2 select pc1/user", exp_level(dv, 2'd1, 1'b1, 1'b0, 1'b0), dv == 2'd2);
                apply(words[w], 4'(d), 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
                check("R2 select pc3/write", exp_level(dv, 2'd3, 1'b0, 1'b0, 1'b0), dv == 2'd2);
            end
        end
    endtask

    task automatic t_top_field();
        apply(32'hC000_0000, 4'd15, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R2 R4 field 15 manager", 2'd2, 1'b0);
        apply(32'h8000_0000, 4'd15, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R2 R5 field 15 reserved", 2'd0, 1'b1);
    endtask

    task automatic t_grant_edges();
        apply(32'h1, 4'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R10 RO read granted", 2'd1, 1'b0);
        apply(32'h1, 4'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R10 RO write denied", 2'd1, 1'b0);
        apply(32'h1, 4'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R9 both protect bits", 2'd0, 1'b0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_select();
        t_top_field();
        sweep_domain(2'd0, "R3 blocked");
        sweep_domain(2'd3, "R4 manager");
        sweep_domain(2'd2, "R5 reserved");
        sweep_domain(2'd1, "R6 R7 R8 R9 R10 client");
        t_grant_edges();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule